// File: doc/BRIEF.md
# Masked PCI Configuration Header

This block answers byte-wide configuration cycles for one PCI device function. Each access names a function number and a byte offset within a 256-byte header. Writes pass through a per-offset write mask before they are stored. Identification bytes are preset at reset and cannot be changed. Function numbers that have no header read back as all ones, and writes to them are dropped.

Parameters select three build variants. The bridge variant adds narrow masks on a few device-specific registers. The memory-window variant tracks a 4 KB-aligned 32-bit base address held in the header. It also emits a one-cycle notification, together with the new base, whenever software writes one of the base bytes. The redirect variant makes function 1 reach a second, independent header with its own class code and header-type byte, so a companion function can sit behind the same responder.

Read data is registered. It is loaded on the clock edge that samples a read strobe and holds its value until the next read. The block sits behind a configuration-cycle decoder that has already split bus transactions into single bytes.

Top module: `cfg_hdr_top`

## Requirements
- R1: A function number other than 0 (and other than 1 when redirect is enabled) reads FFh, and a write to it changes no stored byte in any header.
- R2: Offsets 00h–04h, 06h–0Bh and 0Eh keep their reset values whatever is written to them.
- R3: At offset 05h only bit 0 accepts write data. Bits 7:1 always read 0.
- R4: With the bridge variant, offset 50h stores bits 4:0, offset 52h stores bits 6:4 (other bits read 0), and offsets 51h, 53h and 54h ignore writes.
- R5: With the memory-window variant, offset 10h ignores writes and offset 11h stores bits 7:4 only. `bar_base` equals the bytes at 13h,12h,11h,10h (13h most significant), so its low 12 bits are always 0.
- R6: A function-0 write to offset 11h, 12h or 13h raises `bar_remap` for exactly one cycle, starting at the clock edge that stores the byte, with `bar_base` already showing the updated value. No other write raises it.
- R7: After reset, function 0 reads: 00h/01h vendor ID (low byte first), 02h/03h device ID, 04h command default, 06h = 80h, 07h = 02h, 09h/0Ah/0Bh the class code from its low byte up, 0Eh the header-type parameter, and 00h at every other offset.
- R8: An offset with no mask rule stores the full written byte.
- R9: With redirect enabled, function 1 reads and writes a second header. That header has the same vendor and device IDs and status, its own class code and header type, command 00h, and only the R2 and R3 rules.
- R10: `cfg_rdata` is reset to 00h, takes the new value at the edge that samples `cfg_rd`, and is otherwise held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_func | input | FUNC_W | Function number of the access |
| cfg_off | input | 8 | Byte offset within the header |
| cfg_wdata | input | 8 | Write data |
| cfg_wr | input | 1 | Write strobe, one byte per cycle |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 8 | Registered read data |
| bar_base | output | 32 | Current memory-window base |
| bar_remap | output | 1 | One-cycle notice that the base was written |

## Verification
The results of a read strobe appear in `cfg_rdata` one edge later. The bench raises the strobe for one cycle and compares the data at the following falling edge, against a bench-side copy of both headers. That copy is updated with masks derived from the requirements. A write's effect on `bar_base` and `bar_remap` is visible right after the storing edge, so both are compared at the falling edge after the write. The bench then checks `bar_remap` one cycle later to confirm it has dropped. A dropped write or an ignored field is confirmed by a later read of that offset, or of the offset in function 0 when the write went to an absent function.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int OFF_W  = 8;
    localparam int DEPTH  = 1 << OFF_W;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [OFF_W-1:0]  off_t;

    typedef enum logic [1:0] {
        ROUTE_PRIMARY,
        ROUTE_SECONDARY,
        ROUTE_ABSENT
    } route_e;

    typedef struct packed {
        logic  wr;
        logic  rd;
        off_t  off;
        byte_t data;
    } cfg_req_t;

    localparam byte_t ABSENT_BYTE = 8'hFF;
    localparam off_t  BAR_B0      = 8'h10;
    localparam off_t  BAR_B1      = 8'h11;
    localparam off_t  BAR_B2      = 8'h12;
    localparam off_t  BAR_B3      = 8'h13;

    // Bits set in the result accept write data; zero means read-only.
    function automatic byte_t write_mask(input off_t off, input bit bridge, input bit bar);
        byte_t m;
        m = 8'hFF;
        case (off)
            8'h00, 8'h01, 8'h02, 8'h03, 8'h04,
            8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B,
            8'h0E:   m = 8'h00;
            8'h05:   m = 8'h01;
            default: ;
        endcase
        if (bridge) begin
            case (off)
                8'h50:                m = 8'h1F;
                8'h52:                m = 8'h70;
                8'h51, 8'h53, 8'h54:  m = 8'h00;
                default: ;
            endcase
        end
        if (bar) begin
            case (off)
                BAR_B0:  m = 8'h00;
                BAR_B1:  m = 8'hF0;
                default: ;
            endcase
        end
        return m;
    endfunction

    function automatic byte_t reset_byte(input off_t off, input logic [15:0] vendor,
                                         input logic [15:0] device, input logic [23:0] klass,
                                         input byte_t hdr, input byte_t cmd);
        byte_t v;
        case (off)
            8'h00:   v = vendor[7:0];
            8'h01:   v = vendor[15:8];
            8'h02:   v = device[7:0];
            8'h03:   v = device[15:8];
            8'h04:   v = cmd;
            8'h06:   v = 8'h80;
            8'h07:   v = 8'h02;
            8'h09:   v = klass[7:0];
            8'h0A:   v = klass[15:8];
            8'h0B:   v = klass[23:16];
            8'h0E:   v = hdr;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic route_e pick_route(input int unsigned func, input bit redirect);
        if (func == 0)                  return ROUTE_PRIMARY;
        else if (func == 1 && redirect) return ROUTE_SECONDARY;
        else                            return ROUTE_ABSENT;
    endfunction

endpackage

// File: rtl/cfg_hdr_space.sv
module cfg_hdr_space
    import cfg_hdr_pkg::*;
#(
    parameter bit          BRIDGE_MASKS = 1'b0,
    parameter bit          BAR_EN       = 1'b0,
    parameter logic [15:0] VENDOR_ID    = 16'h1D5A,
    parameter logic [15:0] DEVICE_ID    = 16'h0A12,
    parameter logic [23:0] CLASS_CODE   = 24'h060000,
    parameter logic [7:0]  HDR_TYPE     = 8'h80,
    parameter logic [7:0]  CMD_RESET    = 8'h07
) (
    input  logic        clk,
    input  logic        rst,
    input  cfg_req_t    req,
    input  logic        sel,
    output byte_t       rd_byte,
    output logic [31:0] bar_word
);

    byte_t mem [DEPTH];
    byte_t mask;
    logic  we;

    assign we      = req.wr && sel;
    assign mask    = write_mask(req.off, BRIDGE_MASKS, BAR_EN);
    assign rd_byte = mem[req.off];

    generate
        if (BAR_EN) begin : g_bar
            assign bar_word = {mem[BAR_B3], mem[BAR_B2], mem[BAR_B1], mem[BAR_B0]};
        end else begin : g_nobar
            assign bar_word = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= reset_byte(off_t'(i), VENDOR_ID, DEVICE_ID, CLASS_CODE, HDR_TYPE, CMD_RESET);
            end
        end else if (we) begin
            mem[req.off] <= (mem[req.off] & ~mask) | (req.data & mask);
        end
    end

    // R2: header-type byte never changes after reset
    a_r2_hdr_type_held: assert property (@(posedge clk) disable iff (rst)
        (we && req.off == 8'h0E) |=> (mem[8'h0E] == $past(mem[8'h0E])));

    // R3: upper bits of the command high byte stay clear
    a_r3_cmd_hi_clear: assert property (@(posedge clk) disable iff (rst)
        (mem[8'h05][7:1] == 7'd0));

    // R7: status bytes keep their preset value
    a_r7_status_fixed: assert property (@(posedge clk) disable iff (rst)
        (mem[8'h06] == 8'h80 && mem[8'h07] == 8'h02));

endmodule

// File: rtl/cfg_hdr_bar_notify.sv
module cfg_hdr_bar_notify
    import cfg_hdr_pkg::*;
#(
    parameter bit BAR_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  cfg_req_t    req,
    input  logic        sel,
    input  logic [31:0] bar_word,
    output logic [31:0] bar_base,
    output logic        bar_remap
);

    logic hit;
    logic remap_q;

    assign hit = BAR_EN && sel && req.wr &&
                 (req.off == BAR_B1 || req.off == BAR_B2 || req.off == BAR_B3);

    always_ff @(posedge clk) begin
        if (rst) remap_q <= 1'b0;
        else     remap_q <= hit;
    end

    assign bar_remap = remap_q;
    assign bar_base  = bar_word;

    // R5: the window is always 4 KB aligned
    a_r5_bar_aligned: assert property (@(posedge clk) disable iff (rst)
        (bar_base[11:0] == 12'h000));

endmodule

// File: rtl/cfg_hdr_top.sv
module cfg_hdr_top
    import cfg_hdr_pkg::*;
#(
    parameter int          FUNC_W       = 3,
    parameter bit          BRIDGE_MASKS = 1'b1,
    parameter bit          BAR_EN       = 1'b1,
    parameter bit          F1_REDIRECT  = 1'b1,
    parameter logic [15:0] VENDOR_ID    = 16'h1D5A,
    parameter logic [15:0] DEVICE_ID    = 16'h0A12,
    parameter logic [23:0] CLASS_CODE   = 24'h060000,
    parameter logic [7:0]  HDR_TYPE     = 8'h80,
    parameter logic [7:0]  CMD_RESET    = 8'h07,
    parameter logic [23:0] SEC_CLASS    = 24'h01018A,
    parameter logic [7:0]  SEC_HDR_TYPE = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FUNC_W-1:0] cfg_func,
    input  logic [7:0]        cfg_off,
    input  logic [7:0]        cfg_wdata,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    output logic [7:0]        cfg_rdata,
    output logic [31:0]       bar_base,
    output logic              bar_remap
);

    cfg_req_t    req;
    route_e      route;
    byte_t       pri_byte;
    byte_t       sec_byte;
    byte_t       rdata_q;
    logic [31:0] pri_bar;
    logic [31:0] sec_bar;
    logic        pri_sel;
    logic        sec_sel;

    assign req     = '{wr: cfg_wr, rd: cfg_rd, off: cfg_off, data: cfg_wdata};
    assign route   = pick_route(int'(cfg_func), F1_REDIRECT);
    assign pri_sel = (route == ROUTE_PRIMARY);
    assign sec_sel = (route == ROUTE_SECONDARY);

    cfg_hdr_space #(
        .BRIDGE_MASKS (BRIDGE_MASKS),
        .BAR_EN       (BAR_EN),
        .VENDOR_ID    (VENDOR_ID),
        .DEVICE_ID    (DEVICE_ID),
        .CLASS_CODE   (CLASS_CODE),
        .HDR_TYPE     (HDR_TYPE),
        .CMD_RESET    (CMD_RESET)
    ) u_primary (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .sel      (pri_sel),
        .rd_byte  (pri_byte),
        .bar_word (pri_bar)
    );

    generate
        if (F1_REDIRECT) begin : g_secondary
            cfg_hdr_space #(
                .BRIDGE_MASKS (1'b0),
                .BAR_EN       (1'b0),
                .VENDOR_ID    (VENDOR_ID),
                .DEVICE_ID    (DEVICE_ID),
                .CLASS_CODE   (SEC_CLASS),
                .HDR_TYPE     (SEC_HDR_TYPE),
                .CMD_RESET    (8'h00)
            ) u_secondary (
                .clk      (clk),
                .rst      (rst),
                .req      (req),
                .sel      (sec_sel),
                .rd_byte  (sec_byte),
                .bar_word (sec_bar)
            );
        end else begin : g_no_secondary
            assign sec_byte = ABSENT_BYTE;
            assign sec_bar  = '0;
        end
    endgenerate

    cfg_hdr_bar_notify #(
        .BAR_EN (BAR_EN)
    ) u_bar (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .sel       (pri_sel),
        .bar_word  (pri_bar | sec_bar),
        .bar_base  (bar_base),
        .bar_remap (bar_remap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= 8'h00;
        end else if (req.rd) begin
            case (route)
                ROUTE_PRIMARY:   rdata_q <= pri_byte;
                ROUTE_SECONDARY: rdata_q <= sec_byte;
                default:         rdata_q <= ABSENT_BYTE;
            endcase
        end
    end

    assign cfg_rdata = rdata_q;

    // R1: absent functions read all ones
    a_r1_absent_reads_ff: assert property (@(posedge clk) disable iff (rst)
        (cfg_rd && route == ROUTE_ABSENT) |=> (cfg_rdata == 8'hFF));

    // R10: read data holds between read strobes
    a_r10_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rd) |=> $stable(cfg_rdata));

    // R6: a base-byte write is followed by the notice
    a_r6_remap_follows: assert property (@(posedge clk) disable iff (rst)
        (BAR_EN && cfg_wr && route == ROUTE_PRIMARY &&
         (cfg_off == 8'h11 || cfg_off == 8'h12 || cfg_off == 8'h13)) |=> bar_remap);

endmodule

// File: tb/tb_cfg_hdr_top.sv
module tb_cfg_hdr_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cfg_func;
    logic [7:0]  cfg_off;
    logic [7:0]  cfg_wdata;
    logic        cfg_wr;
    logic        cfg_rd;
    logic [7:0]  cfg_rdata;
    logic [31:0] bar_base;
    logic        bar_remap;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [7:0] m0 [256];
    logic [7:0] m1 [256];

    always #4 clk = ~clk;

    cfg_hdr_top dut (
        .clk(clk), .rst(rst), .cfg_func(cfg_func), .cfg_off(cfg_off),
        .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_rdata(cfg_rdata), .bar_base(bar_base), .bar_remap(bar_remap)
    );

    function automatic logic [7:0] mask_of(input int o, input bit sec);
        if (o <= 4 || (o >= 6 && o <= 11) || o == 14) return 8'h00;
        if (o == 5) return 8'h01;
        if (sec) return 8'hFF;
        if (o == 'h50) return 8'h1F;
        if (o == 'h52) return 8'h70;
        if (o == 'h51 || o == 'h53 || o == 'h54 || o == 'h10) return 8'h00;
        if (o == 'h11) return 8'hF0;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] default_of(input int o, input bit sec);
        logic [23:0] cc;
        cc = sec ? 24'h01018A : 24'h060000;
        if (o == 0) return 8'h5A;
        if (o == 1) return 8'h1D;
        if (o == 2) return 8'h12;
        if (o == 3) return 8'h0A;
        if (o == 4) return sec ? 8'h00 : 8'h07;
        if (o == 6) return 8'h80;
        if (o == 7) return 8'h02;
        if (o == 9) return cc[7:0];
        if (o == 10) return cc[15:8];
        if (o == 11) return cc[23:16];
        if (o == 14) return sec ? 8'h40 : 8'h80;
        return 8'h00;
    endfunction

    function automatic string tag_of(input int f, input int o);
        if (f > 1) return "R1";
        if (f == 1) return "R9";
        if (o <= 4 || (o >= 6 && o <= 11) || o == 14) return "R2";
        if (o == 5) return "R3";
        if (o >= 'h50 && o <= 'h54) return "R4";
        if (o >= 'h10 && o <= 'h13) return "R5";
        return "R8";
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input int f, input int o, input logic [7:0] d);
        logic [7:0] m;
        bit pulse;
        @(negedge clk);
        cfg_func = 3'(f); cfg_off = 8'(o); cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (f == 0) begin
            m = mask_of(o, 0);
            m0[o] = (m0[o] & ~m) | (d & m);
        end else if (f == 1) begin
            m = mask_of(o, 1);
            m1[o] = (m1[o] & ~m) | (d & m);
        end
        pulse = (f == 0) && (o >= 'h11 && o <= 'h13);
        check(bar_remap == pulse, "R6", 32'(bar_remap), 32'(pulse));
        check(bar_base == {m0[19], m0[18], m0[17], m0[16]}, "R5", bar_base,
              {m0[19], m0[18], m0[17], m0[16]});
        if (pulse) begin
            @(negedge clk);
            check(bar_remap == 1'b0, "R6", 32'(bar_remap), 32'd0);
        end
    endtask

    task automatic rd_byte(input int f, input int o, input string tag);
        logic [7:0] e;
        @(negedge clk);
        cfg_func = 3'(f); cfg_off = 8'(o); cfg_rd = 1'b1;
        @(negedge clk);
        cfg_rd = 1'b0;
        e = (f == 0) ? m0[o] : (f == 1) ? m1[o] : 8'hFF;
        check(cfg_rdata == e, tag, 32'(cfg_rdata), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 256; i++) begin
            m0[i] = default_of(i, 0);
            m1[i] = default_of(i, 1);
        end
        rst = 1'b1; cfg_func = '0; cfg_off = '0; cfg_wdata = '0; cfg_wr = 0; cfg_rd = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state of the outputs
        check(cfg_rdata == 8'h00, "R10", 32'(cfg_rdata), 32'h0);
        check(bar_remap == 1'b0, "R6", 32'(bar_remap), 32'h0);
        check(bar_base == 32'h0, "R5", bar_base, 32'h0);

        // R7 / R9: reset contents of both headers, absent functions R1
        for (int o = 0; o < 16; o++) rd_byte(0, o, "R7");
        for (int o = 0; o < 16; o++) rd_byte(1, o, "R9");
        rd_byte(2, 0, "R1");
        rd_byte(7, 14, "R1");

        // R10: data held without a strobe
        rd_byte(0, 1, "R10");
        held = cfg_rdata;
        cfg_off = 8'h00;
        repeat (4) @(negedge clk);
        check(cfg_rdata == held, "R10", 32'(cfg_rdata), 32'(held));

        // R2 read-only identification, R3 command high byte
        wr_byte(0, 'h00, 8'hFF); rd_byte(0, 'h00, "R2");
        wr_byte(0, 'h0E, 8'h00); rd_byte(0, 'h0E, "R2");
        wr_byte(0, 'h05, 8'hFF); rd_byte(0, 'h05, "R3");
        wr_byte(1, 'h05, 8'hFE); rd_byte(1, 'h05, "R3");

        // R4 bridge masks
        wr_byte(0, 'h50, 8'hFF); rd_byte(0, 'h50, "R4");
        wr_byte(0, 'h52, 8'hFF); rd_byte(0, 'h52, "R4");
        wr_byte(0, 'h51, 8'hAA); rd_byte(0, 'h51, "R4");
        wr_byte(0, 'h54, 8'h55); rd_byte(0, 'h54, "R4");

        // R5 / R6 base window
        wr_byte(0, 'h10, 8'hFF); rd_byte(0, 'h10, "R5");
        wr_byte(0, 'h11, 8'hFF); rd_byte(0, 'h11, "R5");
        wr_byte(0, 'h12, 8'h34);
        wr_byte(0, 'h13, 8'hFE);
        wr_byte(1, 'h12, 8'h77); rd_byte(1, 'h12, "R9");

        // R8 full byte, R1 writes to absent function dropped
        wr_byte(0, 'h80, 8'hA5); rd_byte(0, 'h80, "R8");
        wr_byte(2, 'h80, 8'h3C); rd_byte(0, 'h80, "R1");
        wr_byte(5, 'h40, 8'h3C); rd_byte(0, 'h40, "R1");
        rd_byte(1, 'h40, "R1");

        // Random mix against the bench model
        for (int k = 0; k < 1500; k++) begin
            int f, o, pick;
            logic [7:0] d;
            pick = int'($urandom_range(0, 9));
            f = (pick < 6) ? 0 : (pick < 8) ? 1 : int'($urandom_range(2, 7));
            if ($urandom_range(0, 1) == 0) o = int'($urandom_range(0, 'h1F));
            else if ($urandom_range(0, 1) == 0) o = int'($urandom_range('h4E, 'h56));
            else o = int'($urandom_range(0, 255));
            d = 8'($urandom);
            if ($urandom_range(0, 1) == 0) wr_byte(f, o, d);
            else rd_byte(f, o, tag_of(f, o));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule